// File: doc/BRIEF.md
# Debug Memory Access Sequencer

This block converts single-word memory requests into the ordered chain of commands a debug-port shift engine needs to reach target memory. It sits above the engine. For each request it issues instruction loads, 16-bit data shifts, and set/clear toggles of the target's functional clock, one at a time. Each command waits for the engine's acknowledge before the next is issued. The target CPU is assumed to be halted already.

Three operations are supported:
- **Read** fetches one word from a given address.
- **Write** stores one word at a given address.
- **Quick read** streams consecutive words from wherever the target's program counter points. The target advances that counter by two on each falling edge of the functional clock, so no address is reloaded between words.

Read words come back one at a time with a valid pulse. The end of every request is marked by a single done pulse. The instruction opcodes and the read control value are parameters.

Top module: `dms_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `reqReady` is 1 and `cmdValid`, `done` and `rdValid` are 0.
- R2: Command kind encoding is 0 = instruction load, 1 = 16-bit data shift, 2 = set functional clock, 3 = clear functional clock. An instruction command carries its opcode zero-extended in `cmdData`. Clock commands carry 0.
- R3: A read (`reqOp` 0, and also `reqOp` 3) issues this sequence: clear clock; control instruction; data 0x2409 (bit 0 = 1 means read); address instruction; data = address; data-to-address instruction; set clock; clear clock; data 0x0000.
- R4: A write (`reqOp` 1) issues this sequence: clear clock; control instruction; data 0x2408 (bit 0 = 0 means write); address instruction; data = address; data-to-address instruction; data = write word; set clock; clear clock.
- R5: After a write's clock pulse, the control instruction is loaded again and 0x2409 is shifted, returning the direction to read before `done`.
- R6: The result of the final 0x0000 shift of a read is presented on `rdData`, with `rdValid` high for one cycle, in the cycle after the engine acknowledges that shift.
- R7: A quick read (`reqOp` 2) issues: clear clock; control instruction; data 0x2409; quick instruction. It then issues set clock, clear clock and data 0x0000 once per word, for `reqLen`+1 words, with no address load. Each word's shift result is returned as in R6.
- R8: `cmdValid` and the command fields hold steady until `cmdReady`. No new command is offered while one awaits its acknowledge.
- R9: A request is taken only when `reqReady` is 1. Request inputs are captured at acceptance, so `reqValid` and input changes while busy do not alter the command stream.
- R10: `done` pulses exactly once per request, one cycle after the last command's acknowledge, with `reqReady` high in that cycle. For reads it coincides with the last `rdValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe |
| reqReady | output | 1 | Sequencer idle, request can be taken |
| reqOp | input | 2 | 0 read, 1 write, 2 quick read, 3 read |
| reqAddr | input | DATA_W | Word address for read/write |
| reqWdata | input | DATA_W | Word to write |
| reqLen | input | LEN_W | Quick read word count minus one |
| rdData | output | DATA_W | Returned memory word |
| rdValid | output | 1 | One-cycle strobe for rdData |
| done | output | 1 | One-cycle end-of-request strobe |
| cmdValid | output | 1 | Command offered to shift engine |
| cmdReady | input | 1 | Shift engine accepts command |
| cmdKind | output | 2 | Command kind (R2) |
| cmdData | output | DATA_W | Opcode or shift value |
| engAck | input | 1 | Shift engine finished command |
| engData | input | DATA_W | Value captured from TDO by last shift |

## Verification
A wrong step register or a wrong next-step choice shows up directly in the command stream. It produces a misplaced, repeated or missing command on the next `cmdValid` after the faulty acknowledge. The bench compares every command against an expected list, so such a fault is caught within one command. A wrong direction value or a wrong data source corrupts the behavioural target's memory, which later read words expose. A miscounted quick-read length shows as an extra or missing `rdValid` before `done`.

// File: rtl/dms_pkg.sv
package dms_pkg;

  typedef enum logic [1:0] {
    CMD_IR  = 2'd0,
    CMD_DR  = 2'd1,
    CMD_SET = 2'd2,
    CMD_CLR = 2'd3
  } cmdKindE;

  typedef enum logic [3:0] {
    SEL_ZERO,
    SEL_CTLRD,
    SEL_CTLWR,
    SEL_ADDR,
    SEL_WDATA,
    SEL_IRCTL,
    SEL_IRADDR,
    SEL_IRD2A,
    SEL_IRQUICK
  } dataSelE;

  typedef enum logic [3:0] {
    ST_CLR0,
    ST_IRCTL,
    ST_DRCTL,
    ST_IRADDR,
    ST_DRADDR,
    ST_IRD2A,
    ST_DRWR,
    ST_SET,
    ST_CLR,
    ST_DRRD,
    ST_IRCTL2,
    ST_DRCTL2,
    ST_IRQUICK
  } stepE;

  typedef struct packed {
    logic    load;
    logic    capture;
    dataSelE sel;
  } strobeS;

endpackage

// File: rtl/dms_ctrl.sv
module dms_ctrl
  import dms_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [LEN_W-1:0] reqLen,
  output logic             reqReady,
  output logic             cmdValid,
  input  logic             cmdReady,
  output logic [1:0]       cmdKind,
  input  logic             engAck,
  output logic             done,
  output strobeS           strobe
);

  typedef enum logic [1:0] {PH_IDLE, PH_SEND, PH_WAIT} phaseE;

  phaseE            phase;
  stepE             step;
  stepE             nextStep;
  logic             isWrite;
  logic             isQuick;
  logic [LEN_W-1:0] wordCnt;
  logic             lastStep;
  cmdKindE          kind;
  dataSelE          sel;

  // Command decode for the current step
  always_comb begin
    kind = CMD_CLR;
    sel  = SEL_ZERO;
    unique case (step)
      ST_CLR0:    begin kind = CMD_CLR; sel = SEL_ZERO;    end
      ST_IRCTL:   begin kind = CMD_IR;  sel = SEL_IRCTL;   end
      ST_DRCTL:   begin kind = CMD_DR;  sel = isWrite ? SEL_CTLWR : SEL_CTLRD; end
      ST_IRADDR:  begin kind = CMD_IR;  sel = SEL_IRADDR;  end
      ST_DRADDR:  begin kind = CMD_DR;  sel = SEL_ADDR;    end
      ST_IRD2A:   begin kind = CMD_IR;  sel = SEL_IRD2A;   end
      ST_DRWR:    begin kind = CMD_DR;  sel = SEL_WDATA;   end
      ST_SET:     begin kind = CMD_SET; sel = SEL_ZERO;    end
      ST_CLR:     begin kind = CMD_CLR; sel = SEL_ZERO;    end
      ST_DRRD:    begin kind = CMD_DR;  sel = SEL_ZERO;    end
      ST_IRCTL2:  begin kind = CMD_IR;  sel = SEL_IRCTL;   end
      ST_DRCTL2:  begin kind = CMD_DR;  sel = SEL_CTLRD;   end
      ST_IRQUICK: begin kind = CMD_IR;  sel = SEL_IRQUICK; end
      default:    begin kind = CMD_CLR; sel = SEL_ZERO;    end
    endcase
  end

  // Step ordering per operation
  always_comb begin
    nextStep = ST_CLR0;
    lastStep = 1'b0;
    unique case (step)
      ST_CLR0:    nextStep = ST_IRCTL;
      ST_IRCTL:   nextStep = ST_DRCTL;
      ST_DRCTL:   nextStep = isQuick ? ST_IRQUICK : ST_IRADDR;
      ST_IRQUICK: nextStep = ST_SET;
      ST_IRADDR:  nextStep = ST_DRADDR;
      ST_DRADDR:  nextStep = ST_IRD2A;
      ST_IRD2A:   nextStep = isWrite ? ST_DRWR : ST_SET;
      ST_DRWR:    nextStep = ST_SET;
      ST_SET:     nextStep = ST_CLR;
      ST_CLR:     nextStep = isWrite ? ST_IRCTL2 : ST_DRRD;
      ST_DRRD: begin
        if (isQuick && (wordCnt != '0)) nextStep = ST_SET;
        else lastStep = 1'b1;
      end
      ST_IRCTL2:  nextStep = ST_DRCTL2;
      ST_DRCTL2:  lastStep = 1'b1;
      default:    lastStep = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      step    <= ST_CLR0;
      isWrite <= 1'b0;
      isQuick <= 1'b0;
      wordCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (reqValid) begin
            phase   <= PH_SEND;
            step    <= ST_CLR0;
            isWrite <= (reqOp == 2'd1);
            isQuick <= (reqOp == 2'd2);
            wordCnt <= reqLen;
          end
        end
        PH_SEND: begin
          if (cmdReady) phase <= PH_WAIT;
        end
        PH_WAIT: begin
          if (engAck) begin
            if (lastStep) begin
              phase <= PH_IDLE;
              done  <= 1'b1;
            end else begin
              phase <= PH_SEND;
              step  <= nextStep;
              if (step == ST_DRRD) wordCnt <= wordCnt - 1'b1;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign reqReady       = (phase == PH_IDLE);
  assign cmdValid       = (phase == PH_SEND);
  assign cmdKind        = kind;
  assign strobe.load    = reqValid && (phase == PH_IDLE);
  assign strobe.capture = (phase == PH_WAIT) && engAck && (step == ST_DRRD);
  assign strobe.sel     = sel;

endmodule

// File: rtl/dms_dpath.sv
module dms_dpath
  import dms_pkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int          IR_W     = 8,
  parameter logic [IR_W-1:0] IR_CTL   = 8'h13,
  parameter logic [IR_W-1:0] IR_ADDR  = 8'h83,
  parameter logic [IR_W-1:0] IR_D2A   = 8'h85,
  parameter logic [IR_W-1:0] IR_QUICK = 8'hC3,
  parameter logic [DATA_W-1:0] CTL_READ = 16'h2409
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeS            strobe,
  input  logic [DATA_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] engData,
  output logic [DATA_W-1:0] cmdData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam logic [DATA_W-1:0] CTL_WRITE = CTL_READ & ~(DATA_W'(1));
  localparam logic [DATA_W-1:0] OPC_CTL   = DATA_W'(IR_CTL);
  localparam logic [DATA_W-1:0] OPC_ADDR  = DATA_W'(IR_ADDR);
  localparam logic [DATA_W-1:0] OPC_D2A   = DATA_W'(IR_D2A);
  localparam logic [DATA_W-1:0] OPC_QUICK = DATA_W'(IR_QUICK);

  logic [DATA_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.capture;
      if (strobe.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strobe.capture) rdData <= engData;
    end
  end

  always_comb begin
    unique case (strobe.sel)
      SEL_CTLRD:   cmdData = CTL_READ;
      SEL_CTLWR:   cmdData = CTL_WRITE;
      SEL_ADDR:    cmdData = addrQ;
      SEL_WDATA:   cmdData = wdataQ;
      SEL_IRCTL:   cmdData = OPC_CTL;
      SEL_IRADDR:  cmdData = OPC_ADDR;
      SEL_IRD2A:   cmdData = OPC_D2A;
      SEL_IRQUICK: cmdData = OPC_QUICK;
      default:     cmdData = '0;
    endcase
  end

endmodule

// File: rtl/dms_top.sv
module dms_top
  import dms_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4,
  parameter int IR_W   = 8,
  parameter logic [IR_W-1:0] IR_CTL   = 8'h13,
  parameter logic [IR_W-1:0] IR_ADDR  = 8'h83,
  parameter logic [IR_W-1:0] IR_D2A   = 8'h85,
  parameter logic [IR_W-1:0] IR_QUICK = 8'hC3,
  parameter logic [DATA_W-1:0] CTL_READ = 16'h2409
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [DATA_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LEN_W-1:0]  reqLen,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              done,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [1:0]        cmdKind,
  output logic [DATA_W-1:0] cmdData,
  input  logic              engAck,
  input  logic [DATA_W-1:0] engData
);

  strobeS strobe;

  dms_ctrl #(.LEN_W(LEN_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqLen(reqLen),
    .reqReady(reqReady), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdKind(cmdKind), .engAck(engAck), .done(done), .strobe(strobe)
  );

  dms_dpath #(
    .DATA_W(DATA_W), .IR_W(IR_W), .IR_CTL(IR_CTL), .IR_ADDR(IR_ADDR),
    .IR_D2A(IR_D2A), .IR_QUICK(IR_QUICK), .CTL_READ(CTL_READ)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .engData(engData), .cmdData(cmdData),
    .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: rtl/dms_chk.sv
module dms_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              done,
  input logic              rdValid,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [1:0]        cmdKind,
  input logic [DATA_W-1:0] cmdData,
  input logic              engAck
);

  logic outstanding;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outstanding <= 1'b0;
    else if (cmdValid && cmdReady) outstanding <= 1'b1;
    else if (engAck) outstanding <= 1'b0;
  end

  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdKind) && $stable(cmdData));

  // R8
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rstN)
    outstanding |-> !cmdValid);

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady && !done);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> reqReady);

  // R6
  word_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(engAck));

endmodule

bind dms_top dms_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .done(done), .rdValid(rdValid), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .cmdKind(cmdKind), .cmdData(cmdData), .engAck(engAck)
);

// File: tb/test_dms_top.sv
`timescale 1ns/1ps
module test_dms_top;

  localparam logic [7:0]  OC_CTL = 8'h13, OC_ADDR = 8'h83, OC_D2A = 8'h85, OC_QUICK = 8'hC3;
  localparam logic [15:0] CRD = 16'h2409, CWR = 16'h2408;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN, reqValid, reqReady, rdValid, done, cmdValid, cmdReady, engAck;
  logic [1:0]  reqOp, cmdKind;
  logic [15:0] reqAddr, reqWdata, rdData, cmdData, engData;
  logic [3:0]  reqLen;

  dms_top #(.DATA_W(16), .LEN_W(4), .IR_W(8), .IR_CTL(OC_CTL), .IR_ADDR(OC_ADDR),
            .IR_D2A(OC_D2A), .IR_QUICK(OC_QUICK), .CTL_READ(CRD)) i_dms_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqLen(reqLen), .rdData(rdData),
    .rdValid(rdValid), .done(done), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdKind(cmdKind), .cmdData(cmdData), .engAck(engAck), .engData(engData)
  );

  int checks = 0, errors = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural target
  logic [15:0] mem [16];
  logic [15:0] shadow [16];
  logic [7:0]  tIr;
  logic [15:0] tCtl, tAddr, tMdb, tPc, tLatch;
  logic        tClk;

  function automatic int idx(logic [15:0] a);
    return int'((a >> 1) & 16'hF);
  endfunction

  function automatic logic [15:0] modelStep(logic [1:0] k, logic [15:0] d);
    logic [15:0] r = 16'h0;
    case (k)
      2'd0: tIr = d[7:0];
      2'd1: begin
        if (tIr == OC_CTL) tCtl = d;
        else if (tIr == OC_ADDR) tAddr = d;
        else if (tIr == OC_D2A) begin
          if (tCtl[0]) r = mem[idx(tAddr)];
          else begin r = tMdb; tMdb = d; end
        end else if (tIr == OC_QUICK) r = tLatch;
      end
      2'd2: tClk = 1'b1;
      default: begin
        if (tClk) begin
          if (tIr == OC_D2A && !tCtl[0]) mem[idx(tAddr)] = tMdb;
          if (tIr == OC_QUICK) begin tLatch = mem[idx(tPc)]; tPc = tPc + 16'd2; end
        end
        tClk = 1'b0;
      end
    endcase
    return r;
  endfunction

  // expected command stream
  logic [1:0]  expKind [64];
  logic [15:0] expData [64];
  string       expReq  [64];
  int          expWr, expRd;
  logic [15:0] expWord [16];
  int          nWords;

  task automatic push(logic [1:0] k, logic [15:0] d, string r);
    expKind[expWr] = k; expData[expWr] = d; expReq[expWr] = r; expWr++;
  endtask

  // shift engine model
  initial begin
    cmdReady = 1'b0; engAck = 1'b0; engData = 16'h0;
    @(posedge rstN);
    forever begin
      @(negedge clk);
      if (cmdValid) begin
        cmdReady = ($urandom % 3) != 0;
        if (cmdReady) begin
          logic [1:0]  k;
          logic [15:0] d;
          int          w;
          k = cmdKind; d = cmdData;
          if (expRd < expWr)
            chk(k == expKind[expRd] && d == expData[expRd], expReq[expRd], "command",
                int'({k, d}), int'({expKind[expRd], expData[expRd]}));
          else
            chk(1'b0, "R3", "unexpected command", int'({k, d}), 0);
          expRd++;
          engData = modelStep(k, d);
          @(negedge clk);
          cmdReady = 1'b0;
          w = $urandom % 3;
          repeat (w) @(negedge clk);
          chk(!cmdValid, "R8", "command offered while outstanding", cmdValid, 0);
          engAck = 1'b1;
          @(negedge clk);
          engAck = 1'b0;
        end
      end else cmdReady = 1'b0;
    end
  end

  task automatic doReq(logic [1:0] op, logic [15:0] a, logic [15:0] wd, logic [3:0] len, bit poke);
    int got = 0, cyc = 0;
    expWr = 0; expRd = 0; nWords = 0;
    push(2'd3, 16'h0, "R2");
    push(2'd0, {8'h0, OC_CTL}, "R2");
    if (op == 2'd1) begin
      push(2'd1, CWR, "R4");  push(2'd0, {8'h0, OC_ADDR}, "R4"); push(2'd1, a, "R4");
      push(2'd0, {8'h0, OC_D2A}, "R4"); push(2'd1, wd, "R4");
      push(2'd2, 16'h0, "R4"); push(2'd3, 16'h0, "R4");
      push(2'd0, {8'h0, OC_CTL}, "R5"); push(2'd1, CRD, "R5");
      shadow[idx(a)] = wd;
    end else if (op == 2'd2) begin
      push(2'd1, CRD, "R7"); push(2'd0, {8'h0, OC_QUICK}, "R7");
      tPc = a;
      for (int i = 0; i <= int'(len); i++) begin
        push(2'd2, 16'h0, "R7"); push(2'd3, 16'h0, "R7"); push(2'd1, 16'h0, "R7");
        expWord[nWords] = shadow[idx(a + 16'(2 * i))]; nWords++;
      end
    end else begin
      push(2'd1, CRD, "R3"); push(2'd0, {8'h0, OC_ADDR}, "R3"); push(2'd1, a, "R3");
      push(2'd0, {8'h0, OC_D2A}, "R3"); push(2'd2, 16'h0, "R3");
      push(2'd3, 16'h0, "R3"); push(2'd1, 16'h0, "R3");
      expWord[0] = shadow[idx(a)]; nWords = 1;
    end
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = a; reqWdata = wd; reqLen = len;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = 16'($urandom); reqWdata = 16'($urandom); reqLen = 4'($urandom);
    forever begin
      if (poke && cyc == 2) begin reqValid = 1'b1; reqOp = 2'd1; end   // R9 ignored while busy
      if (poke && cyc == 3) reqValid = 1'b0;
      if (rdValid) begin
        if (got < nWords) chk(rdData == expWord[got], "R6", "read word", rdData, expWord[got]);
        else chk(1'b0, "R7", "extra word", got, nWords);
        got++;
      end
      if (done) break;
      cyc++;
      if (cyc > 3000) begin chk(1'b0, "R10", "done missing", 0, 1); break; end
      @(negedge clk);
    end
    reqValid = 1'b0;
    chk(got == nWords, op == 2'd2 ? "R7" : "R6", "word count", got, nWords);
    chk(rdValid == (op != 2'd1), "R10", "done with last word", rdValid, op != 2'd1);
    chk(expRd == expWr, "R9", "command count", expRd, expWr);
    chk(reqReady, "R10", "ready with done", reqReady, 1);
    @(negedge clk);
    chk(!done, "R10", "done single pulse", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1));
    rstN = 1'b0; reqValid = 1'b0; reqOp = 2'd0; reqAddr = 16'h0; reqWdata = 16'h0; reqLen = 4'h0;
    tIr = 8'h0; tCtl = CRD; tAddr = 16'h0; tMdb = 16'h0; tPc = 16'h0; tLatch = 16'h0; tClk = 1'b0;
    for (int i = 0; i < 16; i++) begin mem[i] = 16'(16'h1000 + i * 16'h0111); shadow[i] = mem[i]; end
    repeat (3) @(negedge clk);
    chk(reqReady && !cmdValid && !done && !rdValid, "R1", "reset outputs",
        int'({reqReady, cmdValid, done, rdValid}), 4'b1000);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !cmdValid && !done && !rdValid, "R1", "after reset",
        int'({reqReady, cmdValid, done, rdValid}), 4'b1000);
    doReq(2'd0, 16'h0006, 16'h0, 4'd0, 1'b0);          // R3 plain read
    doReq(2'd1, 16'h0006, 16'hBEEF, 4'd0, 1'b0);       // R4 write
    doReq(2'd0, 16'h0006, 16'h0, 4'd0, 1'b0);          // R4 readback
    doReq(2'd3, 16'h001E, 16'h0, 4'd0, 1'b0);          // R3 op 3 as read
    doReq(2'd2, 16'h0004, 16'h0, 4'd0, 1'b0);          // R7 single word
    doReq(2'd2, 16'h0000, 16'h0, 4'd15, 1'b0);         // R7 max length
    doReq(2'd1, 16'h0010, 16'h1234, 4'd0, 1'b1);       // R9 poke while busy
    doReq(2'd0, 16'h0010, 16'h0, 4'd0, 1'b1);          // R9 poke while busy
    for (int n = 0; n < 40; n++) begin
      logic [1:0] op = 2'($urandom % 4);
      doReq(op, 16'(($urandom % 16) * 2), 16'($urandom), 4'($urandom % 6), ($urandom % 4) == 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule